// File: doc/BRIEF.md
# Receive Clock Source Switch with Carrier Sense Gating

This block produces the receive clock, receive data and carrier-sense outputs that a MAC controller sees. Each time receive activity starts, the receive clock passes through an acquisition window while an upstream PLL locks. During that window the receive clock either mirrors the transmit clock or stays low. The two-bit controller mode picks which of these two behaviours applies. The port type sets how long the window lasts. Once the window has run out, the output moves over to the PLL's recovered clock and data. When activity ends, it moves back to the acquisition source so that it is ready for the next frame.

All inputs, including both clocks, are sampled as levels by a fast reference clock. The window timers count cycles of that reference clock. A change of clock source takes effect only in a cycle where the outgoing and incoming sources are both low. Because of this, the output never shows a shortened pulse. Carrier sense reports receive activity or a collision. It is held inactive for a fixed time after the local transmit enable drops, whatever the receiver and collision inputs are doing.

Top module: `rx_clk_crs`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `rxc_o`, `rxd_o` and `crs_o` are 0.
- R2: In modes 2'b00, 2'b01 and 2'b11, during the acquisition window and while the recovered clock is not yet selected, `rxc_o` equals `txc_i` delayed by one reference cycle.
- R3: In mode 2'b10, `rxc_o` stays 0 during the acquisition window.
- R4: With `port_tp_i`=1, the recovered source becomes eligible only after `rx_active_i` has been high for ACQ_TP_CYC consecutive reference cycles.
- R5: With `port_tp_i`=0, the recovered source becomes eligible only after ACQ_AUI_CYC consecutive active cycles.
- R6: The source changes only on a cycle where both the current source and the new source sample low. Once the recovered source is selected, `rxc_o` equals `rec_clk_i` delayed by one cycle.
- R7: `rxd_o` equals `rec_data_i` delayed by one cycle while the recovered source is selected, and is 0 otherwise.
- R8: After `rx_active_i` falls, the output returns to the acquisition source at the next cycle where both sources are low, and the window timer restarts from zero.
- R9: `crs_o` is `rx_active_i | col_i` delayed by one cycle, except during the inhibit window.
- R10: From the first cycle where `tx_en_i` samples 0 after sampling 1, `crs_o` is forced to 0 for INHIBIT_CYC cycles. A new falling edge restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| txc_i | input | 1 | Transmit clock level |
| rec_clk_i | input | 1 | Recovered clock level from the PLL |
| rec_data_i | input | 1 | Recovered data from the PLL |
| rx_active_i | input | 1 | Receive activity present |
| col_i | input | 1 | Collision present |
| port_tp_i | input | 1 | 1 = twisted pair port, 0 = AUI port |
| mode_i | input | 2 | Controller mode; 2'b10 holds the clock low during acquisition |
| tx_en_i | input | 1 | Local transmit enable |
| rxc_o | output | 1 | Receive clock to controller |
| rxd_o | output | 1 | Receive data to controller |
| crs_o | output | 1 | Carrier sense to controller |

## Verification
The hardest case to reach is the source switch itself. The window must expire while the transmit clock and the recovered clock have different periods and phases, so that the switch is deferred by several cycles until both clocks are low together. The same deferral has to happen again on the way back after activity ends. The bench drives the two clocks as free-running level patterns with periods of five and seven reference cycles. It runs every mode and port combination, so both switch directions meet many phase alignments. Carrier-sense blanking is exercised by dropping transmit enable while receive activity and collisions are present, and by dropping it a second time inside a running window to restart it.

// File: rtl/rxcs_pkg.sv
package rxcs_pkg;
  typedef enum logic [1:0] {
    CTL_FAM_A  = 2'b00,
    CTL_FAM_B  = 2'b01,
    CTL_HOLD   = 2'b10,
    CTL_FAM_C  = 2'b11
  } ctl_mode_e;

  function automatic logic mode_holds_low(input ctl_mode_e m);
    return (m == CTL_HOLD);
  endfunction
endpackage

// File: rtl/rxcs_acq_timer.sv
module rxcs_acq_timer #(
  parameter int ACQ_TP_CYC  = 110,
  parameter int ACQ_AUI_CYC = 90
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_active_i,
  input  logic port_tp_i,
  output logic done_o
);
  localparam int MAXC = (ACQ_TP_CYC > ACQ_AUI_CYC) ? ACQ_TP_CYC : ACQ_AUI_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LAST_TP  = CW'(ACQ_TP_CYC - 1);
  localparam logic [CW-1:0] LAST_AUI = CW'(ACQ_AUI_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          done_q;

  assign last = port_tp_i ? LAST_TP : LAST_AUI;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!rx_active_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_q == last) begin
      done_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/rxcs_clk_switch.sv
module rxcs_clk_switch (
  input  logic clk,
  input  logic rst,
  input  logic txc_i,
  input  logic rec_clk_i,
  input  logic rec_data_i,
  input  logic hold_low_i,
  input  logic want_rec_i,
  output logic sel_q_o,
  output logic sel_next_o,
  output logic rxc_o,
  output logic rxd_o
);
  logic acq_src;
  logic sel_q, sel_d;
  logic rxc_q, rxd_q;

  assign acq_src = hold_low_i ? 1'b0 : txc_i;

  // Move only when both candidate sources are low: no shortened pulse.
  always_comb begin
    sel_d = sel_q;
    if ((want_rec_i != sel_q) && !acq_src && !rec_clk_i)
      sel_d = want_rec_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      rxc_q <= 1'b0;
      rxd_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      rxc_q <= sel_d ? rec_clk_i : acq_src;
      rxd_q <= sel_d & rec_data_i;
    end
  end

  assign sel_q_o    = sel_q;
  assign sel_next_o = sel_d;
  assign rxc_o      = rxc_q;
  assign rxd_o      = rxd_q;
endmodule

// File: rtl/rxcs_crs_gate.sv
module rxcs_crs_gate #(
  parameter int INHIBIT_CYC = 220
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en_i,
  input  logic rx_active_i,
  input  logic col_i,
  output logic blank_o,
  output logic crs_o
);
  localparam int IW = $clog2(INHIBIT_CYC + 1);
  localparam logic [IW-1:0] RELOAD = IW'(INHIBIT_CYC - 1);

  logic          txen_q;
  logic          fall;
  logic [IW-1:0] inh_q;
  logic          crs_q;

  assign fall    = txen_q & ~tx_en_i;
  assign blank_o = fall | (inh_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      txen_q <= 1'b0;
      inh_q  <= '0;
      crs_q  <= 1'b0;
    end else begin
      txen_q <= tx_en_i;
      if (fall)
        inh_q <= RELOAD;
      else if (inh_q != '0)
        inh_q <= inh_q - 1'b1;
      crs_q <= (rx_active_i | col_i) & ~blank_o;
    end
  end

  assign crs_o = crs_q;
endmodule

// File: rtl/rx_clk_crs.sv
module rx_clk_crs #(
  parameter int ACQ_TP_CYC  = 110,
  parameter int ACQ_AUI_CYC = 90,
  parameter int INHIBIT_CYC = 220
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txc_i,
  input  logic       rec_clk_i,
  input  logic       rec_data_i,
  input  logic       rx_active_i,
  input  logic       col_i,
  input  logic       port_tp_i,
  input  logic [1:0] mode_i,
  input  logic       tx_en_i,
  output logic       rxc_o,
  output logic       rxd_o,
  output logic       crs_o
);
  import rxcs_pkg::*;

  ctl_mode_e mode;
  logic      acq_done;
  logic      want_rec;
  logic      hold_low;
  logic      sel_q, sel_next;
  logic      blank;

  assign mode     = ctl_mode_e'(mode_i);
  assign hold_low = mode_holds_low(mode);
  assign want_rec = rx_active_i & acq_done;

  rxcs_acq_timer #(
    .ACQ_TP_CYC (ACQ_TP_CYC),
    .ACQ_AUI_CYC(ACQ_AUI_CYC)
  ) timer_i (
    .clk        (clk),
    .rst        (rst),
    .rx_active_i(rx_active_i),
    .port_tp_i  (port_tp_i),
    .done_o     (acq_done)
  );

  rxcs_clk_switch switch_i (
    .clk        (clk),
    .rst        (rst),
    .txc_i      (txc_i),
    .rec_clk_i  (rec_clk_i),
    .rec_data_i (rec_data_i),
    .hold_low_i (hold_low),
    .want_rec_i (want_rec),
    .sel_q_o    (sel_q),
    .sel_next_o (sel_next),
    .rxc_o      (rxc_o),
    .rxd_o      (rxd_o)
  );

  rxcs_crs_gate #(
    .INHIBIT_CYC(INHIBIT_CYC)
  ) crs_i (
    .clk        (clk),
    .rst        (rst),
    .tx_en_i    (tx_en_i),
    .rx_active_i(rx_active_i),
    .col_i      (col_i),
    .blank_o    (blank),
    .crs_o      (crs_o)
  );
endmodule

// File: rtl/rx_clk_crs_chk.sv
module rx_clk_crs_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_q,
  input logic       sel_next,
  input logic       acq_done,
  input logic [1:0] mode_i,
  input logic       tx_en_i,
  input logic       rx_active_i,
  input logic       col_i,
  input logic       rxc_o,
  input logic       crs_o
);
  // R6: a source change never leaves the output high
  a_r6_switch_when_low: assert property (@(posedge clk) disable iff (rst)
    (sel_q != $past(sel_q)) |-> !rxc_o);

  // R4, R5: recovered source is taken only once the window has expired
  a_r4_r5_switch_after_window: assert property (@(posedge clk) disable iff (rst)
    (sel_q && !$past(sel_q)) |-> $past(acq_done));

  // R3: hold-low mode keeps the clock low on the acquisition source
  a_r3_hold_low: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10 && !sel_next) |=> !rxc_o);

  // R10: a transmit-enable fall blanks carrier sense
  a_r10_inhibit_start: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en_i) |=> !crs_o);

  // R9: carrier sense needs activity or collision
  a_r9_crs_source: assert property (@(posedge clk) disable iff (rst)
    crs_o |-> $past(rx_active_i || col_i));
endmodule

bind rx_clk_crs rx_clk_crs_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .sel_q      (sel_q),
  .sel_next   (sel_next),
  .acq_done   (acq_done),
  .mode_i     (mode_i),
  .tx_en_i    (tx_en_i),
  .rx_active_i(rx_active_i),
  .col_i      (col_i),
  .rxc_o      (rxc_o),
  .crs_o      (crs_o)
);

// File: tb/rx_clk_crs_tb_top.sv
`timescale 1ns/1ps
module rx_clk_crs_tb_top;
  localparam int TP_W  = 110;
  localparam int AUI_W = 90;
  localparam int INH   = 220;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txc_i = 0, rec_clk_i = 0, rec_data_i = 0;
  logic rx_active_i = 0, col_i = 0, port_tp_i = 0, tx_en_i = 0;
  logic [1:0] mode_i = 2'b00;
  logic rxc_o, rxd_o, crs_o;

  always #10 clk = ~clk;

  rx_clk_crs #(.ACQ_TP_CYC(TP_W), .ACQ_AUI_CYC(AUI_W), .INHIBIT_CYC(INH)) dut_i (
    .clk(clk), .rst(rst), .txc_i(txc_i), .rec_clk_i(rec_clk_i),
    .rec_data_i(rec_data_i), .rx_active_i(rx_active_i), .col_i(col_i),
    .port_tp_i(port_tp_i), .mode_i(mode_i), .tx_en_i(tx_en_i),
    .rxc_o(rxc_o), .rxd_o(rxd_o), .crs_o(crs_o));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // free-running clock patterns, periods 5 and 7, plus pseudo data
  int tph = 0, rph = 3;
  logic [7:0] lfsr = 8'h5A;
  always @(posedge clk) begin
    #3;
    tph = (tph + 1) % 5;
    rph = (rph + 1) % 7;
    txc_i = (tph < 2);
    rec_clk_i = (rph < 3);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rec_data_i = lfsr[0];
  end

  // behavioural reference
  int m_cnt = 0, m_inh = 0;
  bit m_done = 0, m_sel = 0, m_txen = 0;
  bit e_rxc = 0, e_rxd = 0, e_crs = 0;
  bit m_blank_now = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_done = 0; m_sel = 0; m_inh = 0; m_txen = 0;
      e_rxc = 0; e_rxd = 0; e_crs = 0; m_blank_now = 0;
    end else begin
      int lim;
      bit src, want, fall;
      lim  = port_tp_i ? TP_W : AUI_W;
      src  = (mode_i == 2'b10) ? 1'b0 : txc_i;
      want = rx_active_i && m_done;
      if (want != m_sel && !src && !rec_clk_i) m_sel = want;
      e_rxc = m_sel ? rec_clk_i : src;
      e_rxd = m_sel ? rec_data_i : 1'b0;
      if (!rx_active_i) begin m_cnt = 0; m_done = 0; end
      else if (m_cnt == lim - 1) m_done = 1;
      else m_cnt++;
      fall = m_txen && !tx_en_i;
      m_blank_now = fall || (m_inh != 0);
      e_crs = (rx_active_i || col_i) && !m_blank_now;
      if (fall) m_inh = INH - 1;
      else if (m_inh != 0) m_inh--;
      m_txen = tx_en_i;
    end
  end

  task automatic check1(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      string tag;
      int lim;
      lim = port_tp_i ? TP_W : AUI_W;
      if (rx_active_i && m_cnt >= lim - 3 && !m_sel) tag = port_tp_i ? "R4" : "R5";
      else if (m_sel) tag = "R6";
      else if (!rx_active_i) tag = "R8";
      else tag = (mode_i == 2'b10) ? "R3" : "R2";
      check1(tag, rxc_o, e_rxc, "rxc_o");
      check1("R7", rxd_o, e_rxd, "rxd_o");
      check1(m_blank_now ? "R10" : "R9", crs_o, e_crs, "crs_o");
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    step(4);
    check1("R1", rxc_o, 1'b0, "rxc_o in reset");
    check1("R1", rxd_o, 1'b0, "rxd_o in reset");
    check1("R1", crs_o, 1'b0, "crs_o in reset");
    rst = 0;
    @(negedge clk);
    check1("R1", crs_o, 1'b0, "crs_o after reset");
    check1("R1", rxd_o, 1'b0, "rxd_o after reset");
    step(1);
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 4; m++) begin
        port_tp_i = p[0];
        mode_i = m[1:0];
        step(3);
        rx_active_i = 1;
        step((p ? TP_W : AUI_W) + 40 + m);
        col_i = 1;
        step(6);
        col_i = 0;
        rx_active_i = 0;
        step(25);
      end
    end
    // R10: inhibit while activity and collision, with restart
    mode_i = 2'b00; port_tp_i = 1;
    tx_en_i = 1; step(20);
    rx_active_i = 1;
    step(10);
    tx_en_i = 0; step(100);
    col_i = 1;
    tx_en_i = 1; step(5);
    tx_en_i = 0; step(INH + 10);
    col_i = 0;
    rx_active_i = 0;
    step(20);
    // short activity bursts that end inside the window
    for (int k = 0; k < 5; k++) begin
      rx_active_i = 1; step(20 + 7 * k);
      rx_active_i = 0; step(4 + k);
    end
    step(10);
    finish_up();
  end
endmodule